// File: doc/BRIEF.md
# Flash Interrupt and Status Controller

This block holds the interrupt status word, the four controller error flags and the two system configuration words of a flash controller, and drives the controller's interrupt and ready pins. A separate command engine reports each finished operation as a one-cycle event with a kind code and a failure flag. This block turns those events into done bits, a master interrupt bit and error flags. Software reaches the state through a small register port. Writes to that port take effect on the clock edge, and reads are combinational from the selected register.

The interrupt pin is the master interrupt bit combined with a polarity bit in configuration word 1. Software acknowledges interrupts by writing a mask that is ANDed into the status word. When the master bit ends up clear, the error flags are wiped as well. A new command is handed to the engine only while no interrupt is pending. A command written while the master bit is set is dropped. The command path, the event inputs and the pins are plain control signals with no handshake: the engine takes an issued command in the cycle it is pulsed and never stalls this block.

Register selects on `reg_sel`: 0 = configuration 1, 1 = configuration 2, 2 = interrupt status, 3 = controller status (read-only), 4 = command. Event kinds on `evt_kind`: 0 = load, 1 = program, 2 = erase, 3 = core reset, 4 = generic command, 5 to 7 = unrecognised command.

Top module: `flash_irq_ctrl`

## Requirements
- R1: After the asynchronous cold reset (`rst_n` low), the registers read as follows: configuration 1 reads 0x40C0, configuration 2 reads 0x0000, interrupt status reads 0x8080, controller status reads 0x0000 and command reads 0x0000. `rdy_o` is 1.
- R2: A warm reset (`warm_rst` high at a clock edge) or a core-reset event (kind 3) loads configuration 1 with 0x40C0, configuration 2 with 0, interrupt status with 0x8010 and controller status with 0, and sets `rdy_o` to 1. It takes priority over any register write in the same cycle and leaves the command register unchanged.
- R3: A completion event ORs bit 15 (master) into interrupt status, together with the done bit for its kind: load sets bit 7, program sets bit 6, erase sets bit 5. A generic event sets bit 15 only.
- R4: Controller status error bits are bit 10 (command), bit 11 (erase), bit 12 (program) and bit 13 (load). A failed load, program or erase event sets bit 10 and its own bit, and still sets the master and done bits. A failed generic event sets bit 10 only. An unrecognised-command event (kind 5 to 7) always sets bit 10 and bit 15 of interrupt status.
- R5: A write to interrupt status (select 2) replaces it with the old value ANDed with the written value.
- R6: If bit 15 of interrupt status is clear after such a write, controller status bits 10 to 13 are cleared on the same edge.
- R7: `irq_o` equals interrupt status bit 15 XOR the inverse of configuration 1 bit 6, updated from the registered values.
- R8: Configuration 1 reads back with bits 4 to 0 forced to zero (mask 0xFFE0), while configuration 2 reads back all 16 written bits.
- R9: A write to configuration 1 sets `rdy_o` to bit 7 of the written value from the next cycle on.
- R10: A write to the command select while interrupt status bit 15 is set is ignored: `cmd_issue` stays low and the command register keeps its value. Otherwise `cmd_issue` pulses in the write cycle with `cmd_code` equal to the written low byte, and the command register holds the written word from the next cycle.
- R11: When an interrupt-status write and a non-reset event fall in the same cycle, the AND of the write is applied first, and the bits of the event are ORed into the result. Error bits raised by the event survive the clear of R6.
- R12: Writes to the controller status select (3) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous cold reset, active low |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| evt_valid | input | 1 | Completion event strobe from the command engine |
| evt_kind | input | 3 | Kind of completed operation |
| evt_fail | input | 1 | The completed operation failed |
| cmd_issue | output | 1 | Accepted command pulse to the engine |
| cmd_code | output | 8 | Low byte of the accepted command |
| irq_o | output | 1 | Interrupt pin |
| rdy_o | output | 1 | Ready pin |

## Verification
The bench builds the block with its default parameters: reset words 0x40C0 and 0x8010/0x8080 and read mask 0xFFE0. These are the values the requirements quote, so every reset check compares against literal constants. Random runs keep the interrupt-clear mask biased toward dropping bit 15, so the flow moves often between the pending state, where commands are dropped, and the idle state, where they issue. Both polarities of the interrupt pin and the reset-event-versus-write priority are also hit in the same runs.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;
  localparam int WORD_W = 16;
  localparam int SEL_W  = 3;
  localparam int KIND_W = 3;

  localparam logic [SEL_W-1:0] SEL_CFG1 = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CFG2 = 3'd1;
  localparam logic [SEL_W-1:0] SEL_INT  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd3;
  localparam logic [SEL_W-1:0] SEL_CMD  = 3'd4;

  typedef enum logic [KIND_W-1:0] {
    EV_LOAD    = 3'd0,
    EV_PROG    = 3'd1,
    EV_ERASE   = 3'd2,
    EV_CORERST = 3'd3,
    EV_GENERIC = 3'd4
  } evt_kind_e;

  localparam int INT_MASTER = 15;
  localparam int INT_LOAD   = 7;
  localparam int INT_PROG   = 6;
  localparam int INT_ERASE  = 5;

  localparam int ERR_CMD   = 10;
  localparam int ERR_ERASE = 11;
  localparam int ERR_PROG  = 12;
  localparam int ERR_LOAD  = 13;

  localparam logic [WORD_W-1:0] ERR_ALL =
    (WORD_W'(1) << ERR_CMD) | (WORD_W'(1) << ERR_ERASE) |
    (WORD_W'(1) << ERR_PROG) | (WORD_W'(1) << ERR_LOAD);
endpackage

// File: rtl/flash_irq_status.sv
module flash_irq_status
  import flash_irq_pkg::*;
#(
  parameter logic [WORD_W-1:0] INT_COLD = 16'h8080,
  parameter logic [WORD_W-1:0] INT_WARM = 16'h8010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              int_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              evt_valid,
  input  logic [KIND_W-1:0] evt_kind,
  input  logic              evt_fail,
  output logic [WORD_W-1:0] int_q,
  output logic [WORD_W-1:0] stat_q
);
  logic [WORD_W-1:0] int_set, err_set, int_acked, stat_acked;

  always_comb begin
    int_set = '0;
    err_set = '0;
    if (evt_valid) begin
      int_set[INT_MASTER] = 1'b1;
      unique case (evt_kind)
        EV_LOAD: begin
          int_set[INT_LOAD] = 1'b1;
          if (evt_fail) begin
            err_set[ERR_CMD]  = 1'b1;
            err_set[ERR_LOAD] = 1'b1;
          end
        end
        EV_PROG: begin
          int_set[INT_PROG] = 1'b1;
          if (evt_fail) begin
            err_set[ERR_CMD]  = 1'b1;
            err_set[ERR_PROG] = 1'b1;
          end
        end
        EV_ERASE: begin
          int_set[INT_ERASE] = 1'b1;
          if (evt_fail) begin
            err_set[ERR_CMD]   = 1'b1;
            err_set[ERR_ERASE] = 1'b1;
          end
        end
        EV_CORERST: int_set = '0;
        EV_GENERIC: err_set[ERR_CMD] = evt_fail;
        default:    err_set[ERR_CMD] = 1'b1;
      endcase
    end
  end

  always_comb begin
    int_acked  = int_we ? (int_q & wdata) : int_q;
    stat_acked = (int_we && !int_acked[INT_MASTER]) ? (stat_q & ~ERR_ALL) : stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= INT_COLD;
      stat_q <= '0;
    end else if (soft_rst) begin
      int_q  <= INT_WARM;
      stat_q <= '0;
    end else begin
      int_q  <= int_acked | int_set;
      stat_q <= stat_acked | err_set;
    end
  end
endmodule

// File: rtl/flash_irq_cfg.sv
module flash_irq_cfg
  import flash_irq_pkg::*;
#(
  parameter logic [WORD_W-1:0] CFG1_RST = 16'h40C0,
  parameter logic [WORD_W-1:0] CFG2_RST = 16'h0000,
  parameter int               RDY_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cfg1_we,
  input  logic              cfg2_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] cfg1_q,
  output logic [WORD_W-1:0] cfg2_q,
  output logic              rdy_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg1_q <= CFG1_RST;
      cfg2_q <= CFG2_RST;
      rdy_q  <= 1'b1;
    end else if (soft_rst) begin
      cfg1_q <= CFG1_RST;
      cfg2_q <= CFG2_RST;
      rdy_q  <= 1'b1;
    end else begin
      if (cfg1_we) begin
        cfg1_q <= wdata;
        rdy_q  <= wdata[RDY_BIT];
      end
      if (cfg2_we) cfg2_q <= wdata;
    end
  end
endmodule

// File: rtl/flash_irq_cmd.sv
module flash_irq_cmd
  import flash_irq_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              busy,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] cmd_q,
  output logic              issue,
  output logic [CODE_W-1:0] code
);
  assign issue = cmd_we && !busy;
  assign code  = wdata[CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cmd_q <= '0;
    else if (issue) cmd_q <= wdata;
  end
endmodule

// File: rtl/flash_irq_ctrl.sv
module flash_irq_ctrl
  import flash_irq_pkg::*;
#(
  parameter logic [WORD_W-1:0] CFG1_RST  = 16'h40C0,
  parameter logic [WORD_W-1:0] CFG2_RST  = 16'h0000,
  parameter logic [WORD_W-1:0] CFG1_RDM  = 16'hFFE0,
  parameter logic [WORD_W-1:0] INT_COLD  = 16'h8080,
  parameter logic [WORD_W-1:0] INT_WARM  = 16'h8010,
  parameter int               POL_BIT   = 6,
  parameter int               RDY_BIT   = 7,
  parameter int               CODE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              evt_valid,
  input  logic [KIND_W-1:0] evt_kind,
  input  logic              evt_fail,
  output logic              cmd_issue,
  output logic [CODE_W-1:0] cmd_code,
  output logic              irq_o,
  output logic              rdy_o
);
  logic [WORD_W-1:0] int_q, stat_q, cfg1_q, cfg2_q, cmd_q;
  logic soft_rst;

  assign soft_rst = warm_rst || (evt_valid && evt_kind == EV_CORERST);

  flash_irq_status #(.INT_COLD(INT_COLD), .INT_WARM(INT_WARM)) u_status (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .int_we(reg_we && reg_sel == SEL_INT), .wdata(reg_wdata),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_fail(evt_fail),
    .int_q(int_q), .stat_q(stat_q)
  );

  flash_irq_cfg #(.CFG1_RST(CFG1_RST), .CFG2_RST(CFG2_RST), .RDY_BIT(RDY_BIT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cfg1_we(reg_we && reg_sel == SEL_CFG1),
    .cfg2_we(reg_we && reg_sel == SEL_CFG2),
    .wdata(reg_wdata), .cfg1_q(cfg1_q), .cfg2_q(cfg2_q), .rdy_q(rdy_o)
  );

  flash_irq_cmd #(.CODE_W(CODE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_we(reg_we && reg_sel == SEL_CMD),
    .busy(int_q[INT_MASTER]), .wdata(reg_wdata),
    .cmd_q(cmd_q), .issue(cmd_issue), .code(cmd_code)
  );

  assign irq_o = int_q[INT_MASTER] ^ ~cfg1_q[POL_BIT];

  always_comb begin
    unique case (reg_sel)
      SEL_CFG1: reg_rdata = cfg1_q & CFG1_RDM;
      SEL_CFG2: reg_rdata = cfg2_q;
      SEL_INT:  reg_rdata = int_q;
      SEL_STAT: reg_rdata = stat_q;
      SEL_CMD:  reg_rdata = cmd_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/flash_irq_ctrl_chk.sv
module flash_irq_ctrl_chk
  import flash_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              warm_rst,
  input logic              reg_we,
  input logic [SEL_W-1:0]  reg_sel,
  input logic [WORD_W-1:0] reg_wdata,
  input logic              evt_valid,
  input logic [KIND_W-1:0] evt_kind,
  input logic              evt_fail,
  input logic [WORD_W-1:0] int_q,
  input logic [WORD_W-1:0] stat_q,
  input logic [WORD_W-1:0] cmd_q,
  input logic              rdy_o
);
  logic quiet_rst;
  assign quiet_rst = !warm_rst && !(evt_valid && evt_kind == EV_CORERST);

  assert_warm_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> (int_q == 16'h8010 && stat_q == '0 && rdy_o));

  assert_master_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && quiet_rst) |=> int_q[INT_MASTER]);

  assert_fail_cmderr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_fail && quiet_rst && evt_kind != EV_CORERST) |=> stat_q[ERR_CMD]);

  assert_err_wipe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_INT && !reg_wdata[INT_MASTER] && !evt_valid && !warm_rst)
      |=> ((stat_q & ERR_ALL) == '0));

  assert_rdy_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_CFG1 && quiet_rst) |=> (rdy_o == $past(reg_wdata[7])));

  assert_cmd_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_CMD && int_q[INT_MASTER]) |=> $stable(cmd_q));
endmodule

bind flash_irq_ctrl flash_irq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .reg_we(reg_we),
  .reg_sel(reg_sel), .reg_wdata(reg_wdata), .evt_valid(evt_valid),
  .evt_kind(evt_kind), .evt_fail(evt_fail), .int_q(int_q),
  .stat_q(stat_q), .cmd_q(cmd_q), .rdy_o(rdy_o)
);

// File: tb/flash_irq_ctrl_tb_top.sv
`timescale 1ns/100ps
module flash_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic warm_rst = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic evt_valid = 1'b0;
  logic [2:0] evt_kind = 3'd0;
  logic evt_fail = 1'b0;
  logic cmd_issue, irq_o, rdy_o;
  logic [7:0] cmd_code;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] m_cfg1, m_cfg2, m_int, m_stat, m_cmd;
  logic m_rdy;

  always #2 clk = ~clk;

  flash_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_fail(evt_fail),
    .cmd_issue(cmd_issue), .cmd_code(cmd_code), .irq_o(irq_o), .rdy_o(rdy_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq(input logic [15:0] i, input logic [15:0] c1);
    return i[15] ^ ~c1[6];
  endfunction

  task automatic model_reset_words(input logic [15:0] iv);
    m_cfg1 = 16'h40C0; m_cfg2 = 16'h0000; m_int = iv; m_stat = 16'h0000; m_rdy = 1'b1;
  endtask

  // Register reads and pins, sampled in the low phase
  task automatic check_all(input string req);
    reg_sel = 3'd0; #0.2 chk({req, " cfg1 R8"}, reg_rdata, m_cfg1 & 16'hFFE0);
    reg_sel = 3'd1; #0.2 chk({req, " cfg2 R8"}, reg_rdata, m_cfg2);
    reg_sel = 3'd2; #0.2 chk({req, " int R5"}, reg_rdata, m_int);
    reg_sel = 3'd3; #0.2 chk({req, " stat R4"}, reg_rdata, m_stat);
    reg_sel = 3'd4; #0.2 chk({req, " cmd R10"}, reg_rdata, m_cmd);
    chk({req, " irq R7"}, {15'd0, irq_o}, {15'd0, exp_irq(m_int, m_cfg1)});
    chk({req, " rdy R9"}, {15'd0, rdy_o}, {15'd0, m_rdy});
  endtask

  // One clock with the given stimulus; model follows the requirements
  task automatic step(input string req, input logic we, input logic [2:0] sel,
                      input logic [15:0] wd, input logic ev, input logic [2:0] kind,
                      input logic fl, input logic wr);
    logic [15:0] nint, nstat;
    logic exp_issue;
    @(negedge clk);
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    evt_valid = ev; evt_kind = kind; evt_fail = fl; warm_rst = wr;
    exp_issue = we && sel == 3'd4 && !m_int[15];
    #0.5;
    chk({req, " issue R10"}, {15'd0, cmd_issue}, {15'd0, exp_issue});
    if (exp_issue) chk({req, " code R10"}, {8'd0, cmd_code}, {8'd0, wd[7:0]});
    @(posedge clk);
    if (exp_issue) m_cmd = wd;
    if (wr || (ev && kind == 3'd3)) begin
      model_reset_words(16'h8010);            // R2
    end else begin
      nint = m_int; nstat = m_stat;
      if (we) begin
        case (sel)
          3'd0: begin m_cfg1 = wd; m_rdy = wd[7]; end
          3'd1: m_cfg2 = wd;
          3'd2: begin
            nint = m_int & wd;                  // R5
            if (!nint[15]) nstat = nstat & ~16'h3C00;  // R6
          end
          default: ;                            // R12: status select ignored
        endcase
      end
      if (ev) begin                             // R3, R4, R11
        nint[15] = 1'b1;
        case (kind)
          3'd0: begin nint[7] = 1'b1; if (fl) nstat = nstat | 16'h2400; end
          3'd1: begin nint[6] = 1'b1; if (fl) nstat = nstat | 16'h1400; end
          3'd2: begin nint[5] = 1'b1; if (fl) nstat = nstat | 16'h0C00; end
          3'd4: if (fl) nstat = nstat | 16'h0400;
          default: nstat = nstat | 16'h0400;
        endcase
      end
      m_int = nint; m_stat = nstat;
    end
    @(negedge clk);
    reg_we = 1'b0; evt_valid = 1'b0; warm_rst = 1'b0; evt_fail = 1'b0;
    check_all(req);
  endtask

  initial begin
    #150000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset_words(16'h8080); m_cmd = 16'h0000;
    #10 rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 cold");
    chk("R1 cfg1 raw", m_cfg1 & 16'hFFE0, 16'h40C0);

    // R10: command dropped while master pending after cold reset
    step("R10 drop", 1'b1, 3'd4, 16'h00A5, 1'b0, 3'd0, 1'b0, 1'b0);
    // R5/R6: clear master, then accept command
    step("R6 clear", 1'b1, 3'd2, 16'h7FFF, 1'b0, 3'd0, 1'b0, 1'b0);
    step("R10 accept", 1'b1, 3'd4, 16'h1294, 1'b0, 3'd0, 1'b0, 1'b0);
    // R4: failed load
    step("R4 load fail", 1'b0, 3'd0, 16'h0, 1'b1, 3'd0, 1'b1, 1'b0);
    // R12: write to status select ignored
    step("R12 stat wr", 1'b1, 3'd3, 16'hFFFF, 1'b0, 3'd0, 1'b0, 1'b0);
    // R6: ack keeps master set, errors stay
    step("R6 keep", 1'b1, 3'd2, 16'h8000, 1'b0, 3'd0, 1'b0, 1'b0);
    // R11: ack and failed erase same cycle
    step("R11 same", 1'b1, 3'd2, 16'h0000, 1'b1, 3'd2, 1'b1, 1'b0);
    // R4: unknown command event
    step("R4 unknown", 1'b1, 3'd2, 16'h0000, 1'b1, 3'd6, 1'b0, 1'b0);
    // R7/R8/R9: polarity flip and ready drop
    step("R7 pol", 1'b1, 3'd0, 16'h001F, 1'b0, 3'd0, 1'b0, 1'b0);
    step("R8 cfg2", 1'b1, 3'd1, 16'hBEEF, 1'b0, 3'd0, 1'b0, 1'b0);
    // R2: core-reset event beats a cfg1 write
    step("R2 corerst", 1'b1, 3'd0, 16'h0000, 1'b1, 3'd3, 1'b0, 1'b0);
    step("R3 generic", 1'b1, 3'd2, 16'h0000, 1'b1, 3'd4, 1'b1, 1'b0);
    step("R2 warm", 1'b1, 3'd1, 16'h1111, 1'b0, 3'd0, 1'b0, 1'b1);

    for (int n = 0; n < 600; n++) begin
      logic [2:0] s, k;
      logic [15:0] w;
      s = 3'($urandom_range(0, 4));
      k = 3'($urandom_range(0, 7));
      w = 16'($urandom);
      if (s == 3'd2 && $urandom_range(0, 1) == 0) w[15] = 1'b0;
      step("R3 rand", $urandom_range(0, 3) != 0, s, w,
           $urandom_range(0, 3) == 0, k, $urandom_range(0, 1) == 1,
           $urandom_range(0, 40) == 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule